// File: doc/BRIEF.md
# Data Address Translation and Fault Capture Unit

This block sits between a load/store pipeline and a translation lookaside array. For every memory request it chooses the privilege mode the access runs under, checks the returned page-table entry against that mode and the request direction, and produces one registered result. The result is either a physical address or a fault class. The TLB array and the page walker are outside the block; the block only consumes a hit flag, a page frame number and the per-mode permission and fault-on bits of the matched entry.

When an access faults, three software-visible registers record it: the faulting virtual address, a packed status word, and a formatted address that points at the page-table entry for the faulting page. Once written, these registers keep the first fault until software reads the address register, so a burst of later faults cannot overwrite the report. Six event counters tally hits, misses and violations, split into loads and stores.

Top module: `dtx_unit`

## Requirements
- R1: The effective mode is cur_mode when pc_priv is 0. When pc_priv is 1 it is alt_mode if req_alt is 1, otherwise kernel mode. Modes are encoded kernel=0, executive=1, supervisor=2, user=3, and bit m of tlb_rd_perm or tlb_wr_perm grants mode m.
- R2: A virtual address is bad when req_va[63:42] is neither all zeros nor all ones. Such a request gives fault class 1 (general) with the status flags bad-VA and violation, plus the write flag on a store.
- R3: A valid address with tlb_hit=0 sets the miss flag, plus the write flag on a store. The fault class is 4 (table-entry miss) when req_pte_ref=1 and 3 (normal miss) otherwise.
- R4: A store hit without write permission for the effective mode gives class 1, with the flags write and violation, plus fault-on-write when tlb_fonw=1.
- R5: A store hit that has write permission but tlb_fonw=1 gives class 1 with exactly the flags write and fault-on-write.
- R6: A load hit without read permission gives class 2 (violation), with the violation flag, plus fault-on-read when tlb_fonr=1.
- R7: A load hit that has read permission but tlb_fonr=1 gives class 1 with only the fault-on-read flag.
- R8: One cycle after req_valid, rsp_valid is 1. A fault-free access reports class 0 and rsp_paddr = {tlb_ppn, req_va[12:0]} (8 KB pages).
- R9: A captured fault loads fva_reg with the request address, fform_reg with pt_base | (req_va[42:13] << 3), and fstat_reg with opcode in [16:11], register number in [10:6] and flags in [5:0]. The flag bits are: bit 0 write, bit 1 violation, bit 2 fault-on-read, bit 3 fault-on-write, bit 4 bad VA, bit 5 miss.
- R10: A fault is captured and sets flocked only when flocked is 0 or va_read is 1 in the same cycle. While flocked is 1 and va_read is 0, the three registers hold. va_read alone clears flocked.
- R11: Six wrapping counters count loads and stores separately as hits (class 0), misses (class 3 or 4) and violations (class 1 or 2). Each request counts once, in its counter, at the same edge as its response.
- R12: After reset, rsp_valid, flocked, the three fault registers and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_pte_ref | input | 1 | Request is a page-table entry reference |
| req_alt | input | 1 | Request asks for the alternate mode |
| pc_priv | input | 1 | Issuing PC is in privileged code |
| cur_mode | input | 2 | Current data-access mode |
| alt_mode | input | 2 | Alternate mode |
| tlb_hit | input | 1 | TLB matched the address |
| tlb_ppn | input | 27 | Page frame number of the match |
| tlb_rd_perm | input | 4 | Per-mode read enables |
| tlb_wr_perm | input | 4 | Per-mode write enables |
| tlb_fonr | input | 1 | Fault-on-read bit |
| tlb_fonw | input | 1 | Fault-on-write bit |
| inst_opcode | input | 6 | Opcode of the issuing instruction |
| inst_ra | input | 5 | Register number of the issuing instruction |
| pt_base | input | 64 | Page-table base for the formatted address |
| va_read | input | 1 | Software reads the fault address register |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 3 | Fault class: 0 none, 1 general, 2 violation, 3 miss, 4 table-entry miss |
| rsp_paddr | output | 40 | Physical address |
| fva_reg | output | 64 | Captured faulting address |
| fstat_reg | output | 17 | Captured status word |
| fform_reg | output | 64 | Captured formatted address |
| flocked | output | 1 | Fault registers locked |
| cnt_rd_hit | output | 16 | Load hits |
| cnt_rd_miss | output | 16 | Load misses |
| cnt_rd_viol | output | 16 | Load violations |
| cnt_wr_hit | output | 16 | Store hits |
| cnt_wr_miss | output | 16 | Store misses |
| cnt_wr_viol | output | 16 | Store violations |

## Verification
The bench builds the block with its default parameters: 64-bit virtual addresses with 43 implemented bits, 40-bit physical addresses and 8 KB pages. These values put the sign-extension boundary at bit 42 and make the formatted address an easy shift of bits 42:13, so addresses that sit just outside the implemented range can be aimed at directly, both above and below. The 16-bit counters cannot wrap within the run, so each counter check compares an exact count that the bench tallies from its own expected fault classes.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_EXEC   = 2'd1,
        MODE_SUPER  = 2'd2,
        MODE_USER   = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_GENERAL  = 3'd1,
        FLT_ACV      = 3'd2,
        FLT_MISS     = 3'd3,
        FLT_PTE_MISS = 3'd4
    } fault_e;

    localparam int NUM_FLAGS = 6;
    localparam int FB_WRITE  = 0;
    localparam int FB_ACV    = 1;
    localparam int FB_FONR   = 2;
    localparam int FB_FONW   = 3;
    localparam int FB_BADVA  = 4;
    localparam int FB_MISS   = 5;

    localparam int OPC_W  = 6;
    localparam int REG_W  = 5;
    localparam int STAT_W = OPC_W + REG_W + NUM_FLAGS;

    localparam int NUM_CTR = 6;
    localparam int CTR_SEL_W = $clog2(NUM_CTR);

    typedef struct packed {
        fault_e                 fault;
        logic [NUM_FLAGS-1:0]   flags;
    } verdict_t;

    // Counter slot: loads 0..2, stores 3..5; within each: hit, miss, violation
    function automatic logic [CTR_SEL_W-1:0] ctr_slot(input logic store, input fault_e f);
        logic [CTR_SEL_W-1:0] base;
        base = store ? CTR_SEL_W'(3) : CTR_SEL_W'(0);
        case (f)
            FLT_NONE:              return base;
            FLT_MISS, FLT_PTE_MISS: return base + CTR_SEL_W'(1);
            default:               return base + CTR_SEL_W'(2);
        endcase
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input logic [OPC_W-1:0] opc,
                                                      input logic [REG_W-1:0] ra,
                                                      input logic [NUM_FLAGS-1:0] fl);
        return {opc, ra, fl};
    endfunction

endpackage

// File: rtl/dtx_mode_sel.sv
module dtx_mode_sel
    import dtx_pkg::*;
(
    input  logic  pc_priv,
    input  logic  req_alt,
    input  mode_e cur_mode,
    input  mode_e alt_mode,
    output mode_e eff_mode
);
    always_comb begin
        if (!pc_priv)     eff_mode = cur_mode;
        else if (req_alt) eff_mode = alt_mode;
        else              eff_mode = MODE_KERNEL;
    end
endmodule

// File: rtl/dtx_check.sv
module dtx_check
    import dtx_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int IMPL_W = 43,
    parameter int PA_W   = 40,
    parameter int PG_W   = 13
) (
    input  logic [VA_W-1:0]      va,
    input  logic                 store,
    input  logic                 pte_ref,
    input  mode_e                mode,
    input  logic                 hit,
    input  logic [PA_W-PG_W-1:0] ppn,
    input  logic [3:0]           rd_perm,
    input  logic [3:0]           wr_perm,
    input  logic                 fonr,
    input  logic                 fonw,
    output verdict_t             verdict,
    output logic [PA_W-1:0]      paddr
);
    localparam int EXT_W = VA_W - IMPL_W + 1;

    logic [EXT_W-1:0] ext_bits;
    logic             va_ok;
    logic             perm_ok;

    assign ext_bits = va[VA_W-1:IMPL_W-1];
    assign va_ok    = (&ext_bits) | ~(|ext_bits);
    assign perm_ok  = store ? wr_perm[mode] : rd_perm[mode];
    assign paddr    = {ppn, va[PG_W-1:0]};

    always_comb begin
        verdict.flags           = '0;
        verdict.flags[FB_WRITE] = store;
        verdict.fault           = FLT_NONE;
        if (!va_ok) begin
            verdict.fault            = FLT_GENERAL;
            verdict.flags[FB_ACV]    = 1'b1;
            verdict.flags[FB_BADVA]  = 1'b1;
        end else if (!hit) begin
            verdict.fault            = pte_ref ? FLT_PTE_MISS : FLT_MISS;
            verdict.flags[FB_MISS]   = 1'b1;
        end else if (store) begin
            if (!perm_ok) begin
                verdict.fault          = FLT_GENERAL;
                verdict.flags[FB_ACV]  = 1'b1;
                verdict.flags[FB_FONW] = fonw;
            end else if (fonw) begin
                verdict.fault          = FLT_GENERAL;
                verdict.flags[FB_FONW] = 1'b1;
            end
        end else begin
            if (!perm_ok) begin
                verdict.fault          = FLT_ACV;
                verdict.flags[FB_ACV]  = 1'b1;
                verdict.flags[FB_FONR] = fonr;
            end else if (fonr) begin
                verdict.fault          = FLT_GENERAL;
                verdict.flags[FB_FONR] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtx_fault_regs.sv
module dtx_fault_regs
    import dtx_pkg::*;
#(
    parameter int VA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_now,
    input  logic              va_read,
    input  logic [VA_W-1:0]   va_in,
    input  logic [STAT_W-1:0] stat_in,
    input  logic [VA_W-1:0]   form_in,
    output logic [VA_W-1:0]   va_q,
    output logic [STAT_W-1:0] stat_q,
    output logic [VA_W-1:0]   form_q,
    output logic              locked
);
    logic take;
    assign take = fault_now && (!locked || va_read);

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q   <= '0;
            stat_q <= '0;
            form_q <= '0;
            locked <= 1'b0;
        end else if (take) begin
            va_q   <= va_in;
            stat_q <= stat_in;
            form_q <= form_in;
            locked <= 1'b1;
        end else if (va_read) begin
            locked <= 1'b0;
        end
    end
endmodule

// File: rtl/dtx_event_ctr.sv
module dtx_event_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/dtx_unit.sv
module dtx_unit
    import dtx_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int IMPL_W = 43,
    parameter int PA_W   = 40,
    parameter int PG_W   = 13,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_va,
    input  logic                 req_store,
    input  logic                 req_pte_ref,
    input  logic                 req_alt,
    input  logic                 pc_priv,
    input  logic [1:0]           cur_mode,
    input  logic [1:0]           alt_mode,
    input  logic                 tlb_hit,
    input  logic [PA_W-PG_W-1:0] tlb_ppn,
    input  logic [3:0]           tlb_rd_perm,
    input  logic [3:0]           tlb_wr_perm,
    input  logic                 tlb_fonr,
    input  logic                 tlb_fonw,
    input  logic [5:0]           inst_opcode,
    input  logic [4:0]           inst_ra,
    input  logic [VA_W-1:0]      pt_base,
    input  logic                 va_read,
    output logic                 rsp_valid,
    output logic [2:0]           rsp_fault,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic [VA_W-1:0]      fva_reg,
    output logic [16:0]          fstat_reg,
    output logic [VA_W-1:0]      fform_reg,
    output logic                 flocked,
    output logic [CNT_W-1:0]     cnt_rd_hit,
    output logic [CNT_W-1:0]     cnt_rd_miss,
    output logic [CNT_W-1:0]     cnt_rd_viol,
    output logic [CNT_W-1:0]     cnt_wr_hit,
    output logic [CNT_W-1:0]     cnt_wr_miss,
    output logic [CNT_W-1:0]     cnt_wr_viol
);
    localparam int VPN_W    = IMPL_W - PG_W;
    localparam int FORM_PAD = VA_W - VPN_W - 3;

    mode_e            eff_mode;
    verdict_t         verdict;
    logic [PA_W-1:0]  paddr_c;
    logic [VA_W-1:0]  form_c;
    logic [STAT_W-1:0] stat_c;
    logic [NUM_CTR-1:0] inc_vec;
    logic [CNT_W-1:0] cnt [NUM_CTR];

    dtx_mode_sel u_mode (
        .pc_priv (pc_priv),
        .req_alt (req_alt),
        .cur_mode(mode_e'(cur_mode)),
        .alt_mode(mode_e'(alt_mode)),
        .eff_mode(eff_mode)
    );

    dtx_check #(.VA_W(VA_W), .IMPL_W(IMPL_W), .PA_W(PA_W), .PG_W(PG_W)) u_check (
        .va     (req_va),
        .store  (req_store),
        .pte_ref(req_pte_ref),
        .mode   (eff_mode),
        .hit    (tlb_hit),
        .ppn    (tlb_ppn),
        .rd_perm(tlb_rd_perm),
        .wr_perm(tlb_wr_perm),
        .fonr   (tlb_fonr),
        .fonw   (tlb_fonw),
        .verdict(verdict),
        .paddr  (paddr_c)
    );

    assign form_c = pt_base | {{FORM_PAD{1'b0}}, req_va[IMPL_W-1:PG_W], 3'b000};
    assign stat_c = pack_status(inst_opcode, inst_ra, verdict.flags);

    dtx_fault_regs #(.VA_W(VA_W)) u_fregs (
        .clk      (clk),
        .rst      (rst),
        .fault_now(req_valid && (verdict.fault != FLT_NONE)),
        .va_read  (va_read),
        .va_in    (req_va),
        .stat_in  (stat_c),
        .form_in  (form_c),
        .va_q     (fva_reg),
        .stat_q   (fstat_reg),
        .form_q   (fform_reg),
        .locked   (flocked)
    );

    always_comb begin
        inc_vec = '0;
        if (req_valid) inc_vec[ctr_slot(req_store, verdict.fault)] = 1'b1;
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        dtx_event_ctr #(.W(CNT_W)) u_ctr (
            .clk  (clk),
            .rst  (rst),
            .inc  (inc_vec[i]),
            .count(cnt[i])
        );
    end

    assign cnt_rd_hit  = cnt[0];
    assign cnt_rd_miss = cnt[1];
    assign cnt_rd_viol = cnt[2];
    assign cnt_wr_hit  = cnt[3];
    assign cnt_wr_miss = cnt[4];
    assign cnt_wr_viol = cnt[5];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= '0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= verdict.fault;
                rsp_paddr <= paddr_c;
            end
        end
    end
endmodule

// File: rtl/dtx_unit_chk.sv
module dtx_unit_chk #(
    parameter int VA_W = 64,
    parameter int PA_W = 40,
    parameter int PG_W = 13
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            va_read,
    input logic            rsp_valid,
    input logic [2:0]      rsp_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [VA_W-1:0] fva_reg,
    input logic [16:0]     fstat_reg,
    input logic [VA_W-1:0] fform_reg,
    input logic            flocked
);
    assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_hit_offset_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 3'd0) |-> rsp_paddr[PG_W-1:0] == $past(req_va[PG_W-1:0]));

    assert_hold_while_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (flocked && !va_read) |=> ($stable(fva_reg) && $stable(fstat_reg) && $stable(fform_reg) && flocked));

    assert_fault_leaves_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 3'd0) |-> flocked);

    assert_unlock_by_read_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(flocked) |-> $past(va_read));

    assert_capture_has_flags_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(flocked) |-> fstat_reg[5:0] != 6'd0);
endmodule

bind dtx_unit dtx_unit_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_va   (req_va),
    .va_read  (va_read),
    .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr),
    .fva_reg  (fva_reg),
    .fstat_reg(fstat_reg),
    .fform_reg(fform_reg),
    .flocked  (flocked)
);

// File: tb/dtx_unit_test.sv
`timescale 1ns/1ps
module dtx_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0;
    logic [63:0] req_va = '0;
    logic        req_store = 0, req_pte_ref = 0, req_alt = 0, pc_priv = 0;
    logic [1:0]  cur_mode = 0, alt_mode = 0;
    logic        tlb_hit = 1;
    logic [26:0] tlb_ppn = 27'h2AB_CDEF;
    logic [3:0]  tlb_rd_perm = 4'hF, tlb_wr_perm = 4'hF;
    logic        tlb_fonr = 0, tlb_fonw = 0;
    logic [5:0]  inst_opcode = 6'h29;
    logic [4:0]  inst_ra = 5'd17;
    logic [63:0] pt_base = 64'h0000_0200_0000_0000;
    logic        va_read = 0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [39:0] rsp_paddr;
    logic [63:0] fva_reg, fform_reg;
    logic [16:0] fstat_reg;
    logic        flocked;
    logic [15:0] cnt_rd_hit, cnt_rd_miss, cnt_rd_viol, cnt_wr_hit, cnt_wr_miss, cnt_wr_viol;

    always #2.5 clk = ~clk;

    dtx_unit uut (.*);

    int  n_chk = 0, n_bad = 0;
    bit  exp_locked = 0;
    int  e_cnt [6] = '{0, 0, 0, 0, 0, 0};
    bit  done = 0;

    localparam logic [63:0] VA_A = 64'h0000_0001_2345_6ABC;
    localparam logic [63:0] VA_B = 64'h0000_0003_0000_4123;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] form_of(input logic [63:0] va);
        return pt_base | ({34'd0, va[42:13]} << 3);
    endfunction

    task automatic access(input logic [63:0] va, input logic st, input logic [2:0] ef,
                          input logic [5:0] efl, input string tag);
        bit fresh;
        @(negedge clk);
        req_va = va; req_store = st; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " rsp_valid R8"}, 64'(rsp_valid), 64'd1);
        chk({tag, " class"}, 64'(rsp_fault), 64'(ef));
        if (ef == 3'd0) begin
            chk({tag, " paddr R8"}, 64'(rsp_paddr), 64'({tlb_ppn, va[12:0]}));
        end else begin
            fresh = !exp_locked;
            exp_locked = 1;
            if (fresh) begin
                chk({tag, " fva R9"}, fva_reg, va);
                chk({tag, " fstat R9"}, 64'(fstat_reg), 64'({inst_opcode, inst_ra, efl}));
                chk({tag, " fform R9"}, fform_reg, form_of(va));
            end
        end
        chk({tag, " lock R10"}, 64'(flocked), 64'(exp_locked));
        e_cnt[(st ? 3 : 0) + ((ef == 0) ? 0 : (ef == 3 || ef == 4) ? 1 : 2)]++;
    endtask

    task automatic release_lock();
        @(negedge clk); va_read = 1;
        @(negedge clk); va_read = 0;
        exp_locked = 0;
        chk("va_read unlock R10", 64'(flocked), 64'd0);
    endtask

    task automatic check_ctrs(input string tag);
        chk({tag, " rd_hit R11"},  64'(cnt_rd_hit),  64'(e_cnt[0]));
        chk({tag, " rd_miss R11"}, 64'(cnt_rd_miss), 64'(e_cnt[1]));
        chk({tag, " rd_viol R11"}, 64'(cnt_rd_viol), 64'(e_cnt[2]));
        chk({tag, " wr_hit R11"},  64'(cnt_wr_hit),  64'(e_cnt[3]));
        chk({tag, " wr_miss R11"}, 64'(cnt_wr_miss), 64'(e_cnt[4]));
        chk({tag, " wr_viol R11"}, 64'(cnt_wr_viol), 64'(e_cnt[5]));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("reset rsp_valid R12", 64'(rsp_valid), 64'd0);
        chk("reset flocked R12", 64'(flocked), 64'd0);
        chk("reset fva R12", fva_reg, 64'd0);
        chk("reset fstat R12", 64'(fstat_reg), 64'd0);
        chk("reset fform R12", fform_reg, 64'd0);
        check_ctrs("reset R12");
    endtask

    task automatic t_hits();
        access(VA_A, 0, 3'd0, 6'h00, "load hit R8");
        access(VA_B, 1, 3'd0, 6'h00, "store hit R8");
        access(64'hFFFF_FC00_0000_2ABC, 0, 3'd0, 6'h00, "upper-half hit R2");
        access(64'h0000_03FF_FFFF_E001, 0, 3'd0, 6'h00, "top of lower half R2");
        check_ctrs("after hits");
    endtask

    task automatic t_mode();
        cur_mode = 2'd3; tlb_rd_perm = 4'b1000;
        access(VA_A, 0, 3'd0, 6'h00, "user mode read R1");
        pc_priv = 1; req_alt = 0;
        access(VA_A, 0, 3'd2, 6'h02, "priv pc forces kernel R1");
        release_lock();
        req_alt = 1; alt_mode = 2'd2; tlb_rd_perm = 4'b0100;
        access(VA_A, 0, 3'd0, 6'h00, "alt mode supervisor R1");
        pc_priv = 0; req_alt = 0; cur_mode = 2'd1;
        access(VA_A, 0, 3'd2, 6'h02, "alt ignored without priv pc R1");
        release_lock();
        cur_mode = 2'd0; tlb_rd_perm = 4'hF;
    endtask

    task automatic t_badva();
        inst_opcode = 6'h2D; inst_ra = 5'd3;
        access(64'h0000_8000_0000_0000, 1, 3'd1, 6'h13, "bad va store R2");
        release_lock();
        access(64'hFFFF_F800_0000_0000, 0, 3'd1, 6'h12, "bad va load R2");
        release_lock();
    endtask

    task automatic t_miss();
        tlb_hit = 0; req_pte_ref = 1;
        access(VA_A, 0, 3'd4, 6'h20, "pte-ref miss R3");
        release_lock();
        req_pte_ref = 0;
        access(VA_B, 1, 3'd3, 6'h21, "normal store miss R3");
        release_lock();
        tlb_hit = 1;
    endtask

    task automatic t_store_checks();
        inst_opcode = 6'h0F; inst_ra = 5'd30;
        tlb_wr_perm = 4'b1110; tlb_fonw = 1;
        access(VA_B, 1, 3'd1, 6'h0B, "store no perm fonw R4");
        release_lock();
        tlb_fonw = 0;
        access(VA_B, 1, 3'd1, 6'h03, "store no perm R4");
        release_lock();
        tlb_wr_perm = 4'hF; tlb_fonw = 1;
        access(VA_B, 1, 3'd1, 6'h09, "store fonw R5");
        release_lock();
        access(VA_A, 0, 3'd0, 6'h00, "load ignores fonw R5");
        tlb_fonw = 0;
    endtask

    task automatic t_load_checks();
        tlb_rd_perm = 4'b1110; tlb_fonr = 1;
        access(VA_A, 0, 3'd2, 6'h06, "load no perm fonr R6");
        release_lock();
        tlb_fonr = 0;
        access(VA_A, 0, 3'd2, 6'h02, "load no perm R6");
        release_lock();
        tlb_rd_perm = 4'hF; tlb_fonr = 1;
        access(VA_A, 0, 3'd1, 6'h04, "load fonr R7");
        release_lock();
        access(VA_B, 1, 3'd0, 6'h00, "store ignores fonr R7");
        tlb_fonr = 0;
    endtask

    task automatic t_lock();
        tlb_hit = 0;
        access(VA_A, 0, 3'd3, 6'h20, "lock first fault R10");
        inst_opcode = 6'h11;
        access(VA_B, 1, 3'd3, 6'h21, "lock second fault R10");
        chk("lock keeps first va R10", fva_reg, VA_A);
        chk("lock keeps first form R10", fform_reg, form_of(VA_A));
        // read and new fault in the same cycle: new fault is captured
        @(negedge clk);
        req_va = VA_B; req_store = 1; req_valid = 1; va_read = 1;
        @(negedge clk);
        req_valid = 0; va_read = 0;
        e_cnt[4]++;
        chk("read+fault captures va R10", fva_reg, VA_B);
        chk("read+fault status R10", 64'(fstat_reg), 64'({inst_opcode, inst_ra, 6'h21}));
        chk("read+fault stays locked R10", 64'(flocked), 64'd1);
        release_lock();
        tlb_hit = 1;
        check_ctrs("end");
    endtask

    initial begin
        t_reset();
        t_hits();
        t_mode();
        t_badva();
        t_miss();
        t_store_checks();
        t_load_checks();
        t_lock();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule